// File: doc/BRIEF.md
# Streaming 3x3 Matrix Transposer

This block takes a 3x3 matrix as a stream of nine words in row order (a, b, c / d, e, f / g, h, i), one word per clock. It emits the same matrix in column order (a, d, g, b, e, h, c, f, i), one word per clock. A start marker on the first word aligns the internal nine-phase schedule. Matrices may follow one another with no idle cycle, so the sustained rate is one matrix every nine cycles.

The first output word leaves four cycles after the first input word. Storage is four data registers. The lifetime analysis of the stream shows that at most four words are alive in any cycle, so four registers are the minimum. Words move between the registers on a fixed per-phase schedule: each word steps forward one register per cycle. A word that is still needed when it reaches the last register loops back to a free register. The one word whose output cycle equals its input cycle (g) goes straight from the input to the output.

Top module: `mtx3_transposer`

## Requirements
- R1: While reset is applied, and for the first four cycles after it, `out_valid` is low whatever the inputs do.
- R2: Outside reset, `out_valid` in a cycle equals `in_valid` of four cycles earlier.
- R3: Input word p (0..8, row order) of a matrix whose start marker arrives in cycle s appears on `out_data` in cycle s+4+k, where k = 3*(p mod 3) + p/3. The output order is therefore a, d, g, b, e, h, c, f, i.
- R4: The first input word of a matrix appears on `out_data` exactly four cycles after it was accepted.
- R5: The seventh input word (row 2, column 0) appears on `out_data` in the same cycle it is presented on `in_data`, with no register in the path.
- R6: When a new matrix starts in the cycle right after the ninth word of the previous one, `out_valid` stays high across the boundary. The last four words of the earlier matrix come out while the first four words of the next one are accepted, and both matrices are correct.
- R7: After the last matrix, with no further input, its remaining column-order words drain in the four cycles that follow its ninth input word.
- R8: A start marker that arrives after at least four idle cycles realigns the schedule, whatever phase the free-running phase count had reached.
- R9: A reset applied in the middle of a matrix discards the partial matrix: no valid output word appears after reset is released until a new matrix is sent.
- R10: A start marker with `in_valid` low is ignored. In particular, it does not disturb a matrix that is still draining.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present this cycle |
| in_sof | input | 1 | First word of a matrix; honoured only with `in_valid` |
| in_data | input | DATA_W | Input word, row order |
| out_valid | output | 1 | Output word present this cycle |
| out_data | output | DATA_W | Output word, column order |

## Verification
The assertions take for granted that every started matrix delivers nine consecutive valid words, with the start marker on the first word only. They also assume that the next start comes either in the cycle after the ninth word or after at least four idle cycles. The data checks are only meaningful under that framing, so they are keyed to the accepted start marker and the input words that followed it. The stimulus keeps to this framing: it sends whole matrices, back to back or separated by gaps of four or more cycles. The only stray start marker it sends comes with `in_valid` low, and the only matrix it abandons is ended by a reset.

// File: rtl/mtx3_tr_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, types and the fixed register-move schedule of
// the 3x3 transposer. Assumes a 3x3 matrix, so the schedule is fixed and is
// derived from the lifetime analysis of the row-in / column-out stream.
package mtx3_tr_pkg;

    localparam int DIM    = 3;
    localparam int WORDS  = DIM * DIM;          // words per matrix = phases per iteration
    localparam int LAT    = 4;                  // largest lead of output over input
    localparam int NREG   = 4;                  // peak number of live words
    localparam int PH_W   = $clog2(WORDS);
    localparam int RIDX_W = $clog2(NREG);

    // Register indices that the schedule refers to
    localparam int MID_REG   = 2;               // receives the loop-back move
    localparam int SHORT_REG = 1;               // holds words with a two-cycle life

    typedef logic [PH_W-1:0] phase_t;

    localparam phase_t PH_LAST      = phase_t'(WORDS - 1);
    localparam phase_t PH_ZERO_LIFE = phase_t'(2 * DIM);  // row 2, column 0 word
    localparam phase_t PH_LOOP_A    = phase_t'(0);        // last reg loops back to MID_REG
    localparam phase_t PH_LOOP_B    = phase_t'(5);
    localparam phase_t PH_SHORT_A   = phase_t'(0);        // output taken from SHORT_REG
    localparam phase_t PH_SHORT_B   = phase_t'(5);

    typedef enum logic [1:0] {
        LD_INPUT    = 2'd0,
        LD_FORWARD  = 2'd1,
        LD_BACKWARD = 2'd2
    } load_src_t;

    typedef struct packed {
        logic              bypass;
        logic [RIDX_W-1:0] idx;
    } out_src_t;

    // Source of register r at the edge that closes phase ph
    function automatic load_src_t load_src(int unsigned r, phase_t ph);
        if (r == 0)
            return (ph == PH_ZERO_LIFE) ? LD_BACKWARD : LD_INPUT;
        if (r == MID_REG && (ph == PH_LOOP_A || ph == PH_LOOP_B))
            return LD_BACKWARD;
        return LD_FORWARD;
    endfunction

    // Where the output word of phase ph comes from
    function automatic out_src_t out_src(phase_t ph);
        out_src_t s;
        s.bypass = 1'b0;
        s.idx    = RIDX_W'(NREG - 1);
        if (ph == PH_ZERO_LIFE) begin
            s.bypass = 1'b1;
            s.idx    = '0;
        end else if (ph == PH_SHORT_A || ph == PH_SHORT_B) begin
            s.idx    = RIDX_W'(SHORT_REG);
        end
        return s;
    endfunction

endpackage

// File: rtl/mtx3_tr_phase_ctl.sv
`timescale 1ns/1ps
// Phase control: keeps the position within the nine-cycle iteration and the
// output-valid delay line. The phase count runs freely so that a matrix can
// drain without input. An accepted start marker forces phase 0 in the
// same cycle. Assumes the sender frames matrices as nine consecutive words.
module mtx3_tr_phase_ctl
    import mtx3_tr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    input  logic   in_sof,
    output phase_t phase,
    output logic   out_valid
);

    phase_t         phase_q;
    logic [LAT-1:0] vpipe;

    // Current phase: realigned by an accepted start marker
    always_comb phase = (in_valid && in_sof) ? '0 : phase_q;

    // Advance the phase count modulo the iteration length
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else
            phase_q <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end

    // Delay the input valid by the fixed latency
    always_ff @(posedge clk) begin
        if (!rst_n)
            vpipe <= '0;
        else
            vpipe <= {vpipe[LAT-2:0], in_valid};
    end

    assign out_valid = vpipe[LAT-1];

endmodule

// File: rtl/mtx3_tr_reg_bank.sv
`timescale 1ns/1ps
// Register bank: the minimum set of data registers. At each edge every
// register loads either the input word, its forward neighbour, or the last
// register (the loop-back move), as the phase schedule dictates. Assumes the
// phase input follows the iteration, so that no live word is overwritten.
module mtx3_tr_reg_bank
    import mtx3_tr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] hold [NREG]
);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [DATA_W-1:0] q;
        load_src_t         src;

        assign src = load_src(r, phase);

        if (r == 0) begin : g_head
            // Head register: take a new word, or a word looping back
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (src == LD_BACKWARD)
                    q <= hold[NREG-1];
                else
                    q <= in_data;
            end
        end else begin : g_body
            // Body register: shift forward, or take a word looping back
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (src == LD_BACKWARD)
                    q <= hold[NREG-1];
                else
                    q <= hold[r-1];
            end
        end

        assign hold[r] = q;
    end

endmodule

// File: rtl/mtx3_tr_out_mux.sv
`timescale 1ns/1ps
// Output selector: chooses the register that holds the column-order word of
// the current phase, or the input itself for the zero-lifetime word.
// Assumes the register bank has followed the same phase schedule.
module mtx3_tr_out_mux
    import mtx3_tr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  phase_t            phase,
    input  logic [DATA_W-1:0] in_data,
    input  logic [DATA_W-1:0] hold [NREG],
    output logic [DATA_W-1:0] out_data
);

    out_src_t sel;

    // Look up the source for this phase
    assign sel = out_src(phase);

    // Route the chosen word to the output
    always_comb out_data = sel.bypass ? in_data : hold[sel.idx];

endmodule

// File: rtl/mtx3_transposer.sv
`timescale 1ns/1ps
// Top: streaming 3x3 transposer, rows in and columns out, one word per
// clock. Latency is four cycles, and four data registers hold the words.
// Assumes every matrix is nine consecutive valid words with the start marker
// on the first. The next matrix starts either back to back or after four or
// more idle cycles.
module mtx3_transposer
    import mtx3_tr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    phase_t            phase;
    logic [DATA_W-1:0] hold [NREG];

    mtx3_tr_phase_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .phase     (phase),
        .out_valid (out_valid)
    );

    mtx3_tr_reg_bank #(.DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .in_data (in_data),
        .hold    (hold)
    );

    mtx3_tr_out_mux #(.DATA_W(DATA_W)) u_mux (
        .phase    (phase),
        .in_data  (in_data),
        .hold     (hold),
        .out_data (out_data)
    );

endmodule

// File: rtl/mtx3_transposer_chk.sv
`timescale 1ns/1ps
// Checker: port-level properties of the transposer. Assumes the input
// framing described on the top module. The data properties are keyed to the
// accepted start marker and are only armed once the history since reset is
// long enough.
module mtx3_transposer_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sof,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    logic [3:0] since_rst;
    logic       start;

    assign start = in_valid & in_sof;

    // Count cycles since reset, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 4'hF)
            since_rst <= since_rst + 1'b1;
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 4'd4) |-> !out_valid) else $error("out_valid early"); // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'd4) |-> (out_valid == $past(in_valid, 4))) else $error("valid lat"); // R2

    AST_HEAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 4'd12) && $past(start, 4)) |-> (out_data == $past(in_data, 4))) else $error("head"); // R4

    AST_ZERO_LIFE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 4'd12) && $past(start, 6)) |-> (out_data == in_data)) else $error("bypass"); // R5

    AST_LOOPBACK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 4'd12) && $past(start, 7)) |-> (out_data == $past(in_data, 6))) else $error("loopback"); // R3

    AST_LAST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 4'd12) && $past(start, 12)) |-> (out_data == $past(in_data, 4))) else $error("last"); // R7

endmodule

bind mtx3_transposer mtx3_transposer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/mtx3_transposer_tb.sv
`timescale 1ns/1ps
module mtx3_transposer_tb;

    localparam int DW    = 16;
    localparam int WORDS = 9;
    localparam int RING  = 64;
    localparam int NSCEN = 6;

    typedef struct packed {
        logic [7:0] seed;
        logic [7:0] gap;
        logic       stray;
    } scen_t;

    // seed, idle cycles after the matrix, stray start marker in the gap
    localparam scen_t SCEN [NSCEN] = '{
        '{8'h11, 8'd0,  1'b0},
        '{8'h22, 8'd0,  1'b0},
        '{8'h33, 8'd6,  1'b1},
        '{8'h44, 8'd4,  1'b0},
        '{8'h55, 8'd0,  1'b0},
        '{8'h66, 8'd14, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sof = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int            checks = 0;
    int            fails = 0;
    int            cyc = 0;
    bit            done = 1'b0;
    string         vtag = "R1";
    bit            ring_v   [RING];
    logic [DW-1:0] ring_d   [RING];
    string         ring_tag [RING];

    always #2.5 clk = ~clk;

    mtx3_transposer #(.DATA_W(DW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic logic [DW-1:0] word_of(logic [7:0] seed, int p);
        return {seed, 8'(p * 29 + 3)};
    endfunction

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    task automatic clear_ring();
        for (int i = 0; i < RING; i++) ring_v[i] = 1'b0;
    endtask

    // One cycle: drive at the falling edge, then compare against the model
    task automatic tick(input logic v, input logic s, input logic [DW-1:0] d);
        int slot;
        @(negedge clk);
        rst_n = 1'b1; in_valid = v; in_sof = s; in_data = d;
        #1;
        slot = cyc % RING;
        check_eq(vtag, 32'(out_valid), 32'(ring_v[slot]));
        if (ring_v[slot]) check_eq(ring_tag[slot], 32'(out_data), 32'(ring_d[slot]));
        ring_v[slot] = 1'b0;
        cyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, DW'(cyc * 977 + 5));
    endtask

    // Send up to nwords of one matrix; expected column-order slots are booked
    task automatic send_matrix(logic [7:0] seed, int nwords, string head, string tail);
        int start;
        start = cyc;
        for (int p = 0; p < nwords; p++) begin
            int            k;
            int            slot;
            logic [DW-1:0] d;
            k    = (p % 3) * 3 + p / 3;
            slot = (start + 4 + k) % RING;
            d    = word_of(seed, p);
            ring_v[slot] = 1'b1;
            ring_d[slot] = d;
            if (k == 0)      ring_tag[slot] = "R4";
            else if (k == 2) ring_tag[slot] = "R5";
            else if (k >= 5) ring_tag[slot] = tail;
            else             ring_tag[slot] = head;
            tick(1'b1, p == 0, d);
        end
    endtask

    task automatic reset_cycles(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0;
            #1;
            if (i >= 1) check_eq("R1", 32'(out_valid), 32'd0);
            cyc++;
        end
        clear_ring();
    endtask

    initial begin
        clear_ring();
        // reset state and quiet start with junk data (R1)
        reset_cycles(3);
        vtag = "R1";
        idle(3);

        // table of matrices: back to back (R6), gaps (R8), stray marker (R10), drain (R7)
        vtag = "R2";
        for (int s = 0; s < NSCEN; s++) begin
            string head;
            string tail;
            head = (s > 0 && SCEN[s-1].gap != 8'd0) ? "R8" : "R3";
            if (SCEN[s].stray)           tail = "R10";
            else if (SCEN[s].gap == 8'd0) tail = "R6";
            else if (s == NSCEN - 1)      tail = "R7";
            else                          tail = "R3";
            send_matrix(SCEN[s].seed, WORDS, head, tail);
            for (int g = 0; g < int'(SCEN[s].gap); g++)
                tick(1'b0, SCEN[s].stray && g == 1, DW'(cyc * 613 + 1));
        end

        // reset in the middle of a matrix discards it (R9)
        send_matrix(8'h5A, 5, "R9", "R9");
        reset_cycles(2);
        vtag = "R9";
        idle(12);

        // recovery after reset: a fresh matrix and its drain (R3, R7)
        vtag = "R2";
        send_matrix(8'h77, WORDS, "R3", "R7");
        idle(6);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule